// File: doc/BRIEF.md
# Power-of-Two Scale Constant Generator

The block turns a signed 32-bit integer exponent `p` into the floating-point encoding of 2^p, so that a multiplier further down the datapath can scale an operand by a power of two. Three encodings are built side by side: single precision (8-bit exponent field, 23-bit fraction), double precision (11-bit exponent field, 52-bit fraction) and an extended encoding (15-bit exponent field, 64-bit significand whose top bit is an explicit integer bit). A two-bit format code picks which one is delivered.

Exponents inside the normal range give an exact power of two. Exponents that are too large saturate to the infinity encoding. Exponents at or below the negative bias fall into the subnormal range, where a single fraction bit walks down as `p` decreases. One step past the last subnormal bit the block yields the smallest subnormal rather than zero, and anything further down yields zero. The result is registered and comes out one cycle after an input strobe, with a valid flag.

Top module: `pow2_scale_gen`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_word` loads on a strobe and otherwise holds its value. Reset clears both to zero.
- R2: Format codes and packing. Code 0 is single: exponent field in bits 30:23, fraction in 22:0, bits 79:31 zero. Code 1 is double: exponent field in 62:52, fraction in 51:0, bits 79:63 zero. Code 2 is extended: exponent field in 78:64, significand in 63:0 with bit 63 the integer bit, bit 79 zero. Code 3 gives an all-zero word.
- R3: The bias is (2^E-1)>>1 for exponent width E (127, 1023, 16383). For -bias < p <= bias the exponent field is bias+p and the fraction bits are zero.
- R4: For p > bias the exponent field is all ones and the fraction bits are zero.
- R5: For p <= -bias the exponent field is zero, and k = p + bias + W - 1 with W = 23, 52 and 63 for codes 0, 1 and 2. When 0 <= k < W, only fraction bit k is set.
- R6: In the range p <= -bias, k == -1 gives a fraction of exactly 1, and k < -1 gives a fraction of zero.
- R7: In the extended encoding, bit 63 is set for normal and saturated results and clear for subnormal and zero results.
- R8: The sign bit of the result is always zero.
- R9: The extreme inputs 32'h7FFFFFFF and 32'h80000000 give infinity and zero. The internal arithmetic must not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_exp | input | 32 | Signed power p |
| in_fmt | input | 2 | Format code (0 single, 1 double, 2 extended, 3 reserved) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | 80 | Packed constant 2^p |

## Verification
The bench drives the edges of each range for every format: p equal to bias and bias+1, where a wrong comparison either saturates too early or emits an all-ones exponent for a finite value, and p equal to -bias+1 and -bias, where an off-by-one misplaces the normal/subnormal boundary. It walks k through W-1, 0, -1 and -2, which catches a design that clamps to zero instead of returning the smallest subnormal at k == -1, and a design that shifts the fraction bit to the wrong place. The 32-bit extremes expose narrow arithmetic that wraps and turns a huge exponent into a tiny one. In extended mode it checks the explicit integer bit, which a design that treats the encoding like the others would leave clear. Random exponents, both near the ranges and across the full 32 bits, fill in between.

// File: rtl/pow2_pkg.sv
package pow2_pkg;

  localparam int IN_W   = 32;
  localparam int WORD_W = 80;

  localparam int SGL_EXP_W = 8;
  localparam int SGL_LOW_W = 23;
  localparam int DBL_EXP_W = 11;
  localparam int DBL_LOW_W = 52;
  localparam int EXT_EXP_W = 15;
  localparam int EXT_LOW_W = 63;

  typedef enum logic [1:0] {
    FMT_SGL = 2'd0,
    FMT_DBL = 2'd1,
    FMT_EXT = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    RGN_SUB  = 2'd0,
    RGN_NORM = 2'd1,
    RGN_SAT  = 2'd2
  } region_e;

endpackage

// File: rtl/pow2_lane.sv
module pow2_lane
  import pow2_pkg::*;
#(
  parameter int P_W      = 32,
  parameter int EXP_W    = 8,
  parameter int LOW_W    = 23,
  parameter bit EXPLICIT = 1'b0,
  localparam int SIG_W   = LOW_W + (EXPLICIT ? 1 : 0)
) (
  input  logic [P_W-1:0]   p_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o
);
  localparam int A_W  = P_W + 2;
  localparam int BIAS = ((1 << EXP_W) - 1) >> 1;
  localparam logic signed [A_W-1:0] HI_LIM = A_W'(BIAS);
  localparam logic signed [A_W-1:0] LO_LIM = A_W'(-BIAS);
  localparam logic signed [A_W-1:0] K_OFS  = A_W'(BIAS + LOW_W - 1);
  localparam logic signed [A_W-1:0] K_M1   = A_W'(-1);

  logic signed [A_W-1:0] p_w;
  logic signed [A_W-1:0] k_w;
  logic signed [A_W-1:0] e_sum;
  logic [LOW_W-1:0]      sub_low;
  region_e               rgn;

  assign p_w   = $signed({{2{p_i[P_W-1]}}, p_i});
  assign k_w   = p_w + K_OFS;
  assign e_sum = p_w + HI_LIM;

  always_comb begin
    if (p_w > HI_LIM)      rgn = RGN_SAT;
    else if (p_w > LO_LIM) rgn = RGN_NORM;
    else                   rgn = RGN_SUB;
  end

  for (genvar i = 0; i < LOW_W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign sub_low[i] = (k_w == A_W'(i)) || (k_w == K_M1);
    end else begin : g_oth
      assign sub_low[i] = (k_w == A_W'(i));
    end
  end

  logic [LOW_W-1:0] low_sel;

  always_comb begin
    exp_o   = '0;
    low_sel = '0;
    unique case (rgn)
      RGN_SAT:  exp_o = '1;
      RGN_NORM: exp_o = e_sum[EXP_W-1:0];
      default:  low_sel = sub_low;
    endcase
  end

  if (EXPLICIT) begin : g_int
    assign sig_o = {(rgn != RGN_SUB), low_sel};
  end else begin : g_noint
    assign sig_o = low_sel;
  end

endmodule

// File: rtl/pow2_pack.sv
module pow2_pack
  import pow2_pkg::*;
(
  input  logic [1:0]           fmt_i,
  input  logic [SGL_EXP_W-1:0] s_exp_i,
  input  logic [SGL_LOW_W-1:0] s_sig_i,
  input  logic [DBL_EXP_W-1:0] d_exp_i,
  input  logic [DBL_LOW_W-1:0] d_sig_i,
  input  logic [EXT_EXP_W-1:0] x_exp_i,
  input  logic [EXT_LOW_W:0]   x_sig_i,
  output logic [WORD_W-1:0]    word_o
);
  localparam int S_TOT = 1 + SGL_EXP_W + SGL_LOW_W;
  localparam int D_TOT = 1 + DBL_EXP_W + DBL_LOW_W;

  always_comb begin
    unique case (fmt_e'(fmt_i))
      FMT_SGL: word_o = {{(WORD_W - S_TOT){1'b0}}, 1'b0, s_exp_i, s_sig_i};
      FMT_DBL: word_o = {{(WORD_W - D_TOT){1'b0}}, 1'b0, d_exp_i, d_sig_i};
      FMT_EXT: word_o = {1'b0, x_exp_i, x_sig_i};
      default: word_o = '0;
    endcase
  end

endmodule

// File: rtl/pow2_scale_gen.sv
module pow2_scale_gen
  import pow2_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_exp,
  input  logic [1:0]        in_fmt,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  logic [SGL_EXP_W-1:0] s_exp;
  logic [SGL_LOW_W-1:0] s_sig;
  logic [DBL_EXP_W-1:0] d_exp;
  logic [DBL_LOW_W-1:0] d_sig;
  logic [EXT_EXP_W-1:0] x_exp;
  logic [EXT_LOW_W:0]   x_sig;
  logic [WORD_W-1:0]    word_d;

  pow2_lane #(.P_W(IN_W), .EXP_W(SGL_EXP_W), .LOW_W(SGL_LOW_W), .EXPLICIT(1'b0))
    u_sgl (.p_i(in_exp), .exp_o(s_exp), .sig_o(s_sig));

  pow2_lane #(.P_W(IN_W), .EXP_W(DBL_EXP_W), .LOW_W(DBL_LOW_W), .EXPLICIT(1'b0))
    u_dbl (.p_i(in_exp), .exp_o(d_exp), .sig_o(d_sig));

  pow2_lane #(.P_W(IN_W), .EXP_W(EXT_EXP_W), .LOW_W(EXT_LOW_W), .EXPLICIT(1'b1))
    u_ext (.p_i(in_exp), .exp_o(x_exp), .sig_o(x_sig));

  pow2_pack u_pack (
    .fmt_i  (in_fmt),
    .s_exp_i(s_exp), .s_sig_i(s_sig),
    .d_exp_i(d_exp), .d_sig_i(d_sig),
    .x_exp_i(x_exp), .x_sig_i(x_sig),
    .word_o (word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= word_d;
    end
  end

endmodule

// File: rtl/pow2_scale_gen_chk.sv
module pow2_scale_gen_chk
  import pow2_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [IN_W-1:0]   in_exp,
  input logic [1:0]        in_fmt,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word
);
  logic [1:0]             cap_fmt;
  logic signed [IN_W-1:0] cap_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_fmt <= '0;
      cap_p   <= '0;
    end else if (in_valid) begin
      cap_fmt <= in_fmt;
      cap_p   <= $signed(in_exp);
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word));
  p_sgl_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_fmt == FMT_SGL) |-> (out_word[WORD_W-1:31] == '0));
  p_dbl_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_fmt == FMT_DBL) |-> (out_word[WORD_W-1:63] == '0));
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_fmt == FMT_RSV) |-> (out_word == '0));
  p_ext_sign_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_fmt == FMT_EXT) |-> !out_word[WORD_W-1]);
  p_intbit_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_fmt == FMT_EXT) |-> (out_word[63] == (out_word[78:64] != '0)));
  p_sgl_sat_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cap_fmt == FMT_SGL && cap_p > 127) |-> (out_word[30:0] == {8'hFF, 23'd0}));

endmodule

bind pow2_scale_gen pow2_scale_gen_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_exp(in_exp),
  .in_fmt(in_fmt), .out_valid(out_valid), .out_word(out_word)
);

// File: tb/tb_pow2_scale_gen.sv
module tb_pow2_scale_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_exp;
  logic [1:0]  in_fmt;
  logic        out_valid;
  logic [79:0] out_word;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pow2_scale_gen dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_exp(in_exp),
    .in_fmt(in_fmt), .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [79:0] model(input logic [31:0] p, input logic [1:0] fmt);
    longint ew, lw, bias, lp, k, ev;
    logic [63:0] fv;
    logic        ib;
    logic [79:0] w;
    case (fmt)
      2'd0: begin ew = 8;  lw = 23; end
      2'd1: begin ew = 11; lw = 52; end
      2'd2: begin ew = 15; lw = 63; end
      default: return '0;
    endcase
    bias = ((64'sd1 <<< ew) - 1) >>> 1;
    lp   = longint'($signed(p));
    fv   = '0;
    if (lp > bias) begin
      ev = (64'sd1 <<< ew) - 1; ib = 1'b1;
    end else if (lp > -bias) begin
      ev = bias + lp; ib = 1'b1;
    end else begin
      ev = 0; ib = 1'b0;
      k  = lp + bias + lw - 1;
      if (k >= 0 && k < lw) fv = 64'd1 << k;
      else if (k == -1)     fv = 64'd1;
    end
    w = '0;
    case (fmt)
      2'd0: w = (80'(ev) << 23) | 80'(fv);
      2'd1: w = (80'(ev) << 52) | 80'(fv);
      default: w = (80'(ev) << 64) | (80'(ib) << 63) | 80'(fv);
    endcase
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [79:0] act,
                       input logic [79:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run_one(input logic [31:0] p, input logic [1:0] fmt, input string req);
    logic [79:0] e;
    e = model(p, fmt);
    @(negedge clk);
    in_valid = 1'b1; in_exp = p; in_fmt = fmt;
    @(negedge clk);
    in_valid = 1'b0; in_exp = ~p; in_fmt = fmt + 2'd1;
    check(out_valid == 1'b1, {req, " valid R1"}, 80'(out_valid), 80'd1);
    check(out_word == e, req, out_word, e);
  endtask

  function automatic int bias_of(input int fmt);
    return (fmt == 0) ? 127 : (fmt == 1) ? 1023 : 16383;
  endfunction

  function automatic int lw_of(input int fmt);
    return (fmt == 0) ? 23 : (fmt == 1) ? 52 : 63;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [79:0] held;
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_exp = '0; in_fmt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_word == '0, "R1 reset state", out_word, '0);

    for (int f = 0; f < 3; f++) begin
      int b, w;
      b = bias_of(f); w = lw_of(f);
      run_one(32'd0,               2'(f), "R3 p=0");
      run_one(32'd1,               2'(f), "R3 p=1");
      run_one(32'(b),              2'(f), "R3 p=bias");
      run_one(32'(b + 1),          2'(f), "R4 p=bias+1");
      run_one(32'(-b + 1),         2'(f), "R3 p=-bias+1");
      run_one(32'(-b),             2'(f), "R5 p=-bias k=W-1");
      run_one(32'(-b - w + 1),     2'(f), "R5 k=0");
      run_one(32'(-b - 5),         2'(f), "R5 mid subnormal");
      run_one(32'(-b - w),         2'(f), "R6 k=-1");
      run_one(32'(-b - w - 1),     2'(f), "R6 k=-2");
      run_one(32'h7FFF_FFFF,       2'(f), "R9 max p");
      run_one(32'h8000_0000,       2'(f), "R9 min p");
      run_one(32'hFFFF_FFFF,       2'(f), "R8 p=-1");
    end
    run_one(32'd5,        2'd3, "R2 reserved code");
    run_one(32'hFFFF_FF00, 2'd3, "R2 reserved neg");
    run_one(32'd100,      2'd2, "R7 ext normal intbit");
    run_one(32'(-16390),  2'd2, "R7 ext subnormal intbit");

    // R1: output holds when no strobe
    run_one(32'd7, 2'd1, "R1 load");
    held = out_word;
    @(negedge clk);
    in_exp = 32'd99; in_fmt = 2'd0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 idle valid", 80'(out_valid), 80'd0);
    check(out_word == held, "R1 hold word", out_word, held);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] p;
      logic [1:0]  f;
      int          b;
      f = 2'($urandom_range(0, 3));
      b = bias_of(int'(f == 2'd3 ? 2'd2 : f));
      if (i % 3 == 0) p = $urandom;
      else            p = 32'($signed($urandom_range(0, 2 * b + 200)) - b - 100);
      run_one(p, f, "R2 R3 R4 R5 R6 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule